// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block produces one effective address per vector element for memory operations whose encoding is the scalar one, unchanged. A single start pulse captures the operands: a full-width base, a signed immediate, the access size in bytes, an addressing mode, an index width override, a signedness flag and the element count. The block then walks the element numbers upward from zero and presents one address at a time on a valid/ready output. Each address is held until the consumer takes it.

There are three ways to form the stride. The immediate can be scaled by the element number. A zero immediate in unit mode can be replaced by the access size scaled by the element number. In indexed mode a per-element index value is read from its own input port, cut to an override width and widened back, with the signedness flag choosing sign or zero fill. The base is always used at full width. All sums wrap silently.

Top module: `vlsag_top`

## Requirements
- R1: After reset, addr_valid, done and busy are low and elem_idx is zero.
- R2: A start pulse seen while idle captures every operand and begins at element 0. Operand inputs that change after that have no effect on the addresses of that run.
- R3: With mode 2'b01 (immediate stride), address i equals base + sign-extended imm × i.
- R4: With mode 2'b00 (unit stride), address i equals base + op_bytes × i when imm is zero. When imm is nonzero, address i equals base + sign-extended imm × i.
- R5: With mode 2'b10 (indexed), the address for the presented element equals base + widened idx_val + sign-extended imm. idx_val is the value on that port while the element is presented. ew_sel picks the index width: 2'b00 = 64, 2'b01 = 32, 2'b10 = 16, 2'b11 = 8 bits.
- R6: In indexed mode with a narrowed width, idx_signed = 1 sign-extends the cut index and idx_signed = 0 zero-extends it. With ew_sel = 2'b00 the full 64-bit index is used either way.
- R7: All address sums wrap modulo 2^64.
- R8: Elements are presented in increasing order from 0 to vlen-1. While addr_valid is high and addr_ready is low, addr_valid and elem_idx stay unchanged.
- R9: done is high for exactly one cycle, in the cycle after the last element is accepted. With vlen = 0, no address is presented and done is high in the cycle after start.
- R10: busy is high from the cycle after an accepted start through the done cycle. A start pulse during that time is ignored.
- R11: Mode 2'b11 behaves as immediate stride (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; captures all operands when idle |
| mode | input | 2 | Addressing mode: 00 unit, 01 immediate stride, 10 indexed, 11 immediate stride |
| base | input | 64 | Base address, always full width |
| imm | input | 16 | Signed displacement |
| op_bytes | input | 4 | Access size in bytes |
| ew_sel | input | 2 | Index width override: 00=64, 01=32, 10=16, 11=8 |
| idx_signed | input | 1 | 1 = sign-extend the cut index, 0 = zero-extend |
| vlen | input | 8 | Number of elements |
| idx_val | input | 64 | Index value for the element currently presented |
| addr_ready | input | 1 | Consumer accepts the presented address |
| addr_valid | output | 1 | An address is presented |
| addr | output | 64 | Effective address of the presented element |
| elem_idx | output | 8 | Number of the presented element |
| done | output | 1 | One-cycle pulse when a run completes |
| busy | output | 1 | A run is in progress |

## Verification
The hardest case to reach from the ports is a run whose captured operands differ from what sits on the inputs while it runs. Another is a start pulse landing in the middle of a run that is stalled by backpressure. To reach both, the stimulus keeps addr_ready low for two cycles on selected elements. During that stall it pulses start with a different base and mode, then keeps those stray operands on the inputs. Every later address must still match the first run. The index patterns put the top bit of each cut width at one on some elements, so sign and zero fill give different sums. The wrap case starts near the top of the address space.

// File: rtl/vlsag_pkg.sv
package vlsag_pkg;

   typedef enum logic [1:0] {
      AM_UNIT     = 2'b00,
      AM_ELEM     = 2'b01,
      AM_INDEX    = 2'b10,
      AM_ELEM_ALT = 2'b11
   } amode_e;

   typedef enum logic [1:0] {
      EW_D64 = 2'b00,
      EW_W32 = 2'b01,
      EW_H16 = 2'b10,
      EW_B8  = 2'b11
   } ewid_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_FIN  = 2'b10
   } seq_e;

   localparam int unsigned NUM_EW = 4;

endpackage

// File: rtl/vlsag_seq.sv
module vlsag_seq
   import vlsag_pkg::*;
#(
   parameter int unsigned VL_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [VL_W-1:0] vlen,
   input  logic            addr_ready,
   output logic            launch,
   output logic            step,
   output logic            addr_valid,
   output logic            done,
   output logic            busy,
   output logic [VL_W-1:0] elem_idx
);

   localparam logic [VL_W-1:0] CNT_ONE  = VL_W'(1);
   localparam logic [VL_W-1:0] CNT_ZERO = '0;

   seq_e            state_q;
   logic [VL_W-1:0] cnt_q;
   logic [VL_W-1:0] vlen_q;
   logic            fire;
   logic            last;

   assign launch     = start && (state_q == ST_IDLE);
   assign addr_valid = (state_q == ST_RUN);
   assign done       = (state_q == ST_FIN);
   assign busy       = (state_q != ST_IDLE);
   assign elem_idx   = cnt_q;
   assign fire       = addr_valid && addr_ready;
   assign last       = (cnt_q == (vlen_q - CNT_ONE));
   assign step       = fire && !last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= CNT_ZERO;
         vlen_q  <= CNT_ZERO;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  vlen_q  <= vlen;
                  cnt_q   <= CNT_ZERO;
                  state_q <= (vlen == CNT_ZERO) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               if (fire) begin
                  if (last) begin
                     state_q <= ST_FIN;
                  end else begin
                     cnt_q <= cnt_q + CNT_ONE;
                  end
               end
            end
            ST_FIN: begin
               state_q <= ST_IDLE;
               cnt_q   <= CNT_ZERO;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vlsag_stride.sv
module vlsag_stride
   import vlsag_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned IMM_W  = 16,
   parameter int unsigned OPB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              step,
   input  amode_e            mode_q,
   input  logic [IMM_W-1:0]  imm_q,
   input  logic [OPB_W-1:0]  opb_q,
   output logic [ADDR_W-1:0] offset
);

   localparam int unsigned IMM_PAD = ADDR_W - IMM_W;
   localparam int unsigned OPB_PAD = ADDR_W - OPB_W;

   logic [ADDR_W-1:0] imm_wide;
   logic [ADDR_W-1:0] opb_wide;
   logic [ADDR_W-1:0] stride;
   logic [ADDR_W-1:0] acc_q;
   logic              imm_zero;

   assign imm_wide = {{IMM_PAD{imm_q[IMM_W-1]}}, imm_q};
   assign opb_wide = {{OPB_PAD{1'b0}}, opb_q};
   assign imm_zero = (imm_q == '0);

   always_comb begin
      unique case (mode_q)
         AM_UNIT:     stride = imm_zero ? opb_wide : imm_wide;
         AM_ELEM:     stride = imm_wide;
         AM_ELEM_ALT: stride = imm_wide;
         default:     stride = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (launch) begin
         acc_q <= '0;
      end else if (step) begin
         acc_q <= acc_q + stride;
      end
   end

   assign offset = acc_q;

endmodule

// File: rtl/vlsag_idx_ext.sv
module vlsag_idx_ext
   import vlsag_pkg::*;
#(
   parameter int unsigned ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] idx_in,
   input  ewid_e             ew,
   input  logic              sgn,
   output logic [ADDR_W-1:0] idx_out
);

   logic [ADDR_W-1:0] lane [NUM_EW];

   for (genvar k = 0; k < NUM_EW; k++) begin : g_lane
      localparam int unsigned LW = 64 >> k;
      if (LW >= ADDR_W) begin : g_full
         assign lane[k] = idx_in;
      end else begin : g_cut
         localparam int unsigned PAD = ADDR_W - LW;
         logic fill;
         assign fill    = sgn & idx_in[LW-1];
         assign lane[k] = {{PAD{fill}}, idx_in[LW-1:0]};
      end
   end

   always_comb begin
      unique case (ew)
         EW_D64:  idx_out = lane[0];
         EW_W32:  idx_out = lane[1];
         EW_H16:  idx_out = lane[2];
         default: idx_out = lane[3];
      endcase
   end

endmodule

// File: rtl/vlsag_top.sv
module vlsag_top
   import vlsag_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned IMM_W  = 16,
   parameter int unsigned OPB_W  = 4,
   parameter int unsigned VL_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] base,
   input  logic [IMM_W-1:0]  imm,
   input  logic [OPB_W-1:0]  op_bytes,
   input  logic [1:0]        ew_sel,
   input  logic              idx_signed,
   input  logic [VL_W-1:0]   vlen,
   input  logic [ADDR_W-1:0] idx_val,
   input  logic              addr_ready,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] addr,
   output logic [VL_W-1:0]   elem_idx,
   output logic              done,
   output logic              busy
);

   localparam int unsigned IMM_PAD = ADDR_W - IMM_W;

   if (ADDR_W < 64) begin : g_chk_aw
      $error("vlsag_top: ADDR_W must be at least 64");
   end
   if (IMM_W < 2 || IMM_W >= ADDR_W) begin : g_chk_imm
      $error("vlsag_top: IMM_W must lie between 2 and ADDR_W-1");
   end
   if (OPB_W < 1 || OPB_W >= ADDR_W) begin : g_chk_opb
      $error("vlsag_top: OPB_W must lie between 1 and ADDR_W-1");
   end
   if (VL_W < 1 || VL_W > 16) begin : g_chk_vl
      $error("vlsag_top: VL_W must lie between 1 and 16");
   end

   logic              launch;
   logic              step;
   amode_e            mode_q;
   ewid_e             ew_q;
   logic              sgn_q;
   logic [ADDR_W-1:0] base_q;
   logic [IMM_W-1:0]  imm_q;
   logic [OPB_W-1:0]  opb_q;
   logic [ADDR_W-1:0] stride_off;
   logic [ADDR_W-1:0] idx_wide;
   logic [ADDR_W-1:0] imm_wide;
   logic [ADDR_W-1:0] sel_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= AM_UNIT;
         ew_q   <= EW_D64;
         sgn_q  <= 1'b0;
         base_q <= '0;
         imm_q  <= '0;
         opb_q  <= '0;
      end else if (launch) begin
         mode_q <= amode_e'(mode);
         ew_q   <= ewid_e'(ew_sel);
         sgn_q  <= idx_signed;
         base_q <= base;
         imm_q  <= imm;
         opb_q  <= op_bytes;
      end
   end

   vlsag_seq #(
      .VL_W (VL_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .vlen       (vlen),
      .addr_ready (addr_ready),
      .launch     (launch),
      .step       (step),
      .addr_valid (addr_valid),
      .done       (done),
      .busy       (busy),
      .elem_idx   (elem_idx)
   );

   vlsag_stride #(
      .ADDR_W (ADDR_W),
      .IMM_W  (IMM_W),
      .OPB_W  (OPB_W)
   ) u_stride (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .step   (step),
      .mode_q (mode_q),
      .imm_q  (imm_q),
      .opb_q  (opb_q),
      .offset (stride_off)
   );

   vlsag_idx_ext #(
      .ADDR_W (ADDR_W)
   ) u_idx (
      .idx_in  (idx_val),
      .ew      (ew_q),
      .sgn     (sgn_q),
      .idx_out (idx_wide)
   );

   assign imm_wide = {{IMM_PAD{imm_q[IMM_W-1]}}, imm_q};

   always_comb begin
      if (mode_q == AM_INDEX) begin
         sel_off = idx_wide + imm_wide;
      end else begin
         sel_off = stride_off;
      end
   end

   assign addr = base_q + sel_off;

endmodule

// File: rtl/vlsag_chk.sv
module vlsag_chk #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned VL_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_valid,
   input logic              addr_ready,
   input logic [ADDR_W-1:0] addr,
   input logic [VL_W-1:0]   elem_idx,
   input logic              done,
   input logic              busy
);

   localparam logic [VL_W-1:0] IDX_ONE = VL_W'(1);

   // R8: a stalled element stays presented with the same number
   p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !addr_ready) |=> (addr_valid && $stable(elem_idx)));

   // R8: an accepted element is followed by the next one or by done
   p_step_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && addr_ready) |=> (done || ((elem_idx - $past(elem_idx)) == IDX_ONE)));

   // R2: every run opens at element 0
   p_first_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_valid) |-> (elem_idx == '0));

   // R9: done lasts one cycle
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: no address is presented in the done cycle
   p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !addr_valid);

   // R10: presenting and completing both happen while busy
   p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid || done) |-> busy);

   // R7: the address bus never carries unknown bits while presented
   p_addr_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> !$isunknown(addr));

endmodule

bind vlsag_top vlsag_chk #(
   .ADDR_W (ADDR_W),
   .VL_W   (VL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_valid (addr_valid),
   .addr_ready (addr_ready),
   .addr       (addr),
   .elem_idx   (elem_idx),
   .done       (done),
   .busy       (busy)
);

// File: tb/vlsag_top_tb_top.sv
`timescale 1ns/1ps
module vlsag_top_tb_top;

   typedef struct packed {
      logic [1:0]  mode;
      logic [63:0] base;
      logic [15:0] imm;
      logic [3:0]  opb;
      logic [1:0]  ew;
      logic        sgn;
      logic [7:0]  vlen;
      logic [7:0]  seed;
      logic        poke;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VT [NV] = '{
      '{2'b00, 64'h0000_0000_0000_1000, 16'h0000, 4'd8, 2'b00, 1'b0, 8'd4, 8'h00, 1'b0},
      '{2'b00, 64'h0000_0000_0000_2000, 16'h0000, 4'd4, 2'b00, 1'b0, 8'd5, 8'h00, 1'b1},
      '{2'b00, 64'h0000_0000_0000_3000, 16'h0010, 4'd8, 2'b00, 1'b0, 8'd3, 8'h00, 1'b0},
      '{2'b01, 64'h0000_0000_0000_0100, 16'hFFF8, 4'd8, 2'b00, 1'b0, 8'd4, 8'h00, 1'b0},
      '{2'b01, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0010, 4'd8, 2'b00, 1'b0, 8'd3, 8'h00, 1'b0},
      '{2'b10, 64'h0000_0000_0001_0000, 16'h0004, 4'd8, 2'b01, 1'b1, 8'd4, 8'h85, 1'b0},
      '{2'b10, 64'h0000_0000_0001_0000, 16'h0004, 4'd8, 2'b01, 1'b0, 8'd4, 8'h85, 1'b0},
      '{2'b10, 64'h0000_0000_0002_0000, 16'hFFFE, 4'd8, 2'b10, 1'b0, 8'd3, 8'h91, 1'b1},
      '{2'b10, 64'h0000_0000_0003_0000, 16'h0000, 4'd8, 2'b11, 1'b1, 8'd4, 8'hF0, 1'b0},
      '{2'b10, 64'h0000_0000_0004_0000, 16'h0008, 4'd8, 2'b00, 1'b1, 8'd2, 8'hC3, 1'b0},
      '{2'b11, 64'h0000_0000_0005_0000, 16'h0020, 4'd2, 2'b00, 1'b0, 8'd3, 8'h00, 1'b0}
   };

   logic        clk;
   logic        rst_n;
   logic        start;
   logic [1:0]  mode;
   logic [63:0] base;
   logic [15:0] imm;
   logic [3:0]  op_bytes;
   logic [1:0]  ew_sel;
   logic        idx_signed;
   logic [7:0]  vlen;
   logic [63:0] idx_val;
   logic        addr_ready;
   logic        addr_valid;
   logic [63:0] addr;
   logic [7:0]  elem_idx;
   logic        done;
   logic        busy;

   int checks;
   int fails;

   vlsag_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode       (mode),
      .base       (base),
      .imm        (imm),
      .op_bytes   (op_bytes),
      .ew_sel     (ew_sel),
      .idx_signed (idx_signed),
      .vlen       (vlen),
      .idx_val    (idx_val),
      .addr_ready (addr_ready),
      .addr_valid (addr_valid),
      .addr       (addr),
      .elem_idx   (elem_idx),
      .done       (done),
      .busy       (busy)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] idx_of(input logic [7:0] seed, input int i);
      logic [7:0] b;
      b = seed + 8'(i) * 8'h47;
      return {8{b}};
   endfunction

   function automatic logic [63:0] exp_addr(input vec_t v, input int i);
      logic [63:0] sim, ix, e, st;
      sim = {{48{v.imm[15]}}, v.imm};
      if (v.mode == 2'b10) begin
         ix = idx_of(v.seed, i);
         case (v.ew)
            2'b00:   e = ix;
            2'b01:   e = v.sgn ? {{32{ix[31]}}, ix[31:0]} : {32'b0, ix[31:0]};
            2'b10:   e = v.sgn ? {{48{ix[15]}}, ix[15:0]} : {48'b0, ix[15:0]};
            default: e = v.sgn ? {{56{ix[7]}}, ix[7:0]} : {56'b0, ix[7:0]};
         endcase
         return v.base + e + sim;
      end
      st = (v.mode == 2'b00 && v.imm == 16'h0) ? {60'b0, v.opb} : sim;
      return v.base + st * 64'(i);
   endfunction

   function automatic string tag_of(input vec_t v);
      if (v.mode == 2'b00) return "R4";
      if (v.mode == 2'b01) return (v.base[63] ? "R7" : "R3");
      if (v.mode == 2'b11) return "R11";
      return (v.ew == 2'b00) ? "R5" : "R6";
   endfunction

   task automatic apply(input vec_t v);
      mode       = v.mode;
      base       = v.base;
      imm        = v.imm;
      op_bytes   = v.opb;
      ew_sel     = v.ew;
      idx_signed = v.sgn;
      vlen       = v.vlen;
   endtask

   task automatic run_vec(input vec_t v);
      string t;
      t = tag_of(v);
      apply(v);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < int'(v.vlen); i++) begin
         idx_val = idx_of(v.seed, i);
         if (i == 1) begin
            for (int s = 0; s < 2; s++) begin
               addr_ready = 1'b0;
               if (v.poke) begin
                  // R10 / R2: stray start and new operands while stalled
                  start      = (s == 0);
                  mode       = ~v.mode;
                  base       = 64'hDEAD_0000_0000_0000;
                  imm        = 16'h0777;
                  op_bytes   = 4'd1;
                  ew_sel     = ~v.ew;
                  idx_signed = ~v.sgn;
                  vlen       = 8'd1;
               end
               #1;
               chk("R8 held valid", 64'(addr_valid), 64'd1);
               chk("R8 held index", 64'(elem_idx), 64'(i));
               chk({t, " stalled addr"}, addr, exp_addr(v, i));
               @(negedge clk);
               start = 1'b0;
            end
         end
         addr_ready = 1'b1;
         #1;
         chk("R8 valid", 64'(addr_valid), 64'd1);
         chk("R8 index", 64'(elem_idx), 64'(i));
         chk({t, " addr"}, addr, exp_addr(v, i));
         if (v.poke) chk("R10 busy", 64'(busy), 64'd1);
         @(negedge clk);
      end
      addr_ready = 1'b0;
      chk("R9 done after last", 64'(done), 64'd1);
      chk("R9 no valid at done", 64'(addr_valid), 64'd0);
      @(negedge clk);
      chk("R9 done one cycle", 64'(done), 64'd0);
      chk("R10 idle after done", 64'(busy), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      checks     = 0;
      fails      = 0;
      rst_n      = 1'b0;
      start      = 1'b0;
      mode       = 2'b00;
      base       = '0;
      imm        = '0;
      op_bytes   = '0;
      ew_sel     = '0;
      idx_signed = 1'b0;
      vlen       = '0;
      idx_val    = '0;
      addr_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 valid", 64'(addr_valid), 64'd0);
      chk("R1 done", 64'(done), 64'd0);
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 index", 64'(elem_idx), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int n = 0; n < NV; n++) begin
         run_vec(VT[n]);
         @(negedge clk);
      end

      // R9: zero-length run
      apply(VT[0]);
      vlen  = 8'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 vlen0 done", 64'(done), 64'd1);
      chk("R9 vlen0 no valid", 64'(addr_valid), 64'd0);
      @(negedge clk);
      chk("R9 vlen0 done once", 64'(done), 64'd0);
      chk("R9 vlen0 idle", 64'(busy), 64'd0);

      // R2: first element of a fresh run after the zero-length one
      run_vec(VT[3]);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule